// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block is a small translation cache. It maps virtual page numbers to physical page numbers. A request presents a virtual page number and an address-space tag. All entries compare against the request in parallel, and the response comes back in the same cycle. A hit returns the stored physical page number and permission bits. A miss is only reported. Walking the page table and producing the fill data is the job of an external handler, which may be hardware or software. That handler then writes the translation through the fill port.

Each entry holds five items: a valid flag, a virtual page number, a physical page number, three permission bits and an address-space tag. Each entry also carries a global flag, which makes it match under any tag. Because entries are tagged, translations from different address spaces can live side by side. Software can still choose the other policy on an address-space switch. It can drop everything with the flush strobe, or it can remove one mapping with the targeted invalidate.

Top module: `xlat_cache`

## Requirements
- R1: While `lk_valid` is high, `lk_hit` is high in the same cycle exactly when some valid entry has an equal page number and either an equal tag or its global flag set. `lk_ppn` and `lk_perm` then carry that entry's fields. While `lk_valid` is low, `lk_hit` is low.
- R2: After reset no entry is valid, so every lookup misses.
- R3: A flush strobe clears every entry at the next clock edge. It takes priority over an invalidate and a fill in the same cycle, and both of those are then dropped.
- R4: An invalidate clears, at the next edge, every valid entry whose page number matches and whose tag matches or whose global flag is set. All other entries are unchanged. A fill in the same cycle is dropped.
- R5: Entries with the same page number and different tags coexist, and each lookup returns the physical page of its own tag.
- R6: An entry written with its global flag set hits for every lookup tag.
- R7: A fill whose page number and tag equal those of a valid entry overwrites that entry. No other entry changes, and the replacement pointer does not move.
- R8: Any other fill writes the lowest-numbered invalid entry when one exists.
- R9: When all entries are valid, a fill replaces the entry named by a replacement pointer. The pointer is 0 after reset. It advances by one after each such replacement, wrapping from the last entry to 0, and it is not changed by a flush.
- R10: When several entries hit, the lowest-numbered one supplies the response. The permission bits are returned exactly as filled, with bit 0 = present, bit 1 = write and bit 2 = user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | PPN_W | Physical page number on hit |
| lk_perm | output | 3 | Permission bits on hit |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_asid | input | ASID_W | Fill address-space tag |
| fill_ppn | input | PPN_W | Fill physical page number |
| fill_perm | input | 3 | Fill permission bits |
| fill_glb | input | 1 | Fill global flag |
| inv_en | input | 1 | Targeted invalidate |
| inv_vpn | input | VPN_W | Invalidate virtual page number |
| inv_asid | input | ASID_W | Invalidate address-space tag |
| flush_en | input | 1 | Clear every entry |

## Verification
The bench replays every operation on its own table built from the requirements. After each operation it sweeps lookups across 16 page numbers and 4 tags, so a single mistake shows up as a wrong hit or wrong page somewhere in the sweep. The chosen corner cases each have a clear failure signature. If the pointer advances on overwrites or on free-slot fills, later evictions land on the wrong entry and a mapping that should have survived goes missing. If the duplicate check is missing, a refill leaves a stale copy that answers a lookup first. If the priority among strobes is wrong, a fill applied during a flush or an invalidate leaves a mapping that should be gone. If global entries are treated as ordinary ones, their lookups miss under foreign tags.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int PERM_W = 3;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_FLUSH = 2'd1,
      OP_INVAL = 2'd2,
      OP_FILL  = 2'd3
   } xlat_op_e;
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
   import xlat_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [VPN_W-1:0]  w_vpn,
   input  logic [ASID_W-1:0] w_asid,
   input  logic [PPN_W-1:0]  w_ppn,
   input  logic [PERM_W-1:0] w_perm,
   input  logic              w_glb,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   output logic              vld,
   output logic              lk_m,
   output logic              inv_m,
   output logic              dup_m,
   output logic [PPN_W-1:0]  ppn,
   output logic [PERM_W-1:0] perm
);
   logic [VPN_W-1:0]  vpn_q;
   logic [ASID_W-1:0] asid_q;
   logic              glb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         vpn_q  <= '0;
         asid_q <= '0;
         ppn    <= '0;
         perm   <= '0;
         glb_q  <= 1'b0;
      end else if (clr) begin
         vld <= 1'b0;
      end else if (wr) begin
         vld    <= 1'b1;
         vpn_q  <= w_vpn;
         asid_q <= w_asid;
         ppn    <= w_ppn;
         perm   <= w_perm;
         glb_q  <= w_glb;
      end
   end

   assign lk_m  = vld && (vpn_q == lk_vpn)  && (glb_q || asid_q == lk_asid);
   assign inv_m = vld && (vpn_q == inv_vpn) && (glb_q || asid_q == inv_asid);
   assign dup_m = vld && (vpn_q == w_vpn)   && (asid_q == w_asid);

   // R3/R4: a cleared entry is invalid after the edge
   a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !vld);
   // R7/R8: a written entry is valid after the edge
   a_r8_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> vld);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_go,
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] dup,
   output logic [ENTRIES-1:0] sel
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr;
   logic             use_ptr;
   logic             found;

   always_comb begin
      sel     = '0;
      found   = 1'b0;
      use_ptr = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!found && dup[i]) begin
            sel[i] = 1'b1;
            found  = 1'b1;
         end
      end
      for (int i = 0; i < ENTRIES; i++) begin
         if (!found && !valid[i]) begin
            sel[i] = 1'b1;
            found  = 1'b1;
         end
      end
      if (!found) begin
         use_ptr  = 1'b1;
         sel[ptr] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (fill_go && use_ptr)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   a_r7_no_duplicates: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dup));
   a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |-> $onehot(sel));
   a_r9_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_go && use_ptr) |=> $stable(ptr));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              fill_glb,
   input  logic              inv_en,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic              flush_en
);
   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must lie in 2..64");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("xlat_cache: field widths must be positive");
   end

   xlat_op_e op;
   always_comb begin
      if (flush_en)     op = OP_FLUSH;
      else if (inv_en)  op = OP_INVAL;
      else if (fill_en) op = OP_FILL;
      else              op = OP_IDLE;
   end

   logic [ENTRIES-1:0] valid, lk_m, inv_m, dup_m, sel;
   logic [PPN_W-1:0]   e_ppn  [ENTRIES];
   logic [PERM_W-1:0]  e_perm [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      xlat_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (op == OP_FLUSH || (op == OP_INVAL && inv_m[i])),
         .wr       (op == OP_FILL && sel[i]),
         .w_vpn    (fill_vpn),
         .w_asid   (fill_asid),
         .w_ppn    (fill_ppn),
         .w_perm   (fill_perm),
         .w_glb    (fill_glb),
         .lk_vpn   (lk_vpn),
         .lk_asid  (lk_asid),
         .inv_vpn  (inv_vpn),
         .inv_asid (inv_asid),
         .vld      (valid[i]),
         .lk_m     (lk_m[i]),
         .inv_m    (inv_m[i]),
         .dup_m    (dup_m[i]),
         .ppn      (e_ppn[i]),
         .perm     (e_perm[i])
      );
   end

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill_go (op == OP_FILL),
      .valid   (valid),
      .dup     (dup_m),
      .sel     (sel)
   );

   always_comb begin
      lk_hit  = 1'b0;
      lk_ppn  = '0;
      lk_perm = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_valid && lk_m[i]) begin
            lk_hit  = 1'b1;
            lk_ppn  = e_ppn[i];
            lk_perm = e_perm[i];
         end
      end
   end

   a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_en |=> (valid == '0));
   a_r2_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
      (valid == '0) |-> !lk_hit);
   a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit);
   a_r4_inval_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INVAL) |=> ($countones(valid) <= $past($countones(valid))));
   a_r8_fill_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FILL) |=> ($countones(valid) >= $past($countones(valid))));
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   localparam int N = 8;
   localparam int VW = 20, PW = 20, AW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic lk_hit;
   logic [PW-1:0] lk_ppn;
   logic [2:0] lk_perm;
   logic fill_en = 1'b0, fill_glb = 1'b0, inv_en = 1'b0, flush_en = 1'b0;
   logic [VW-1:0] fill_vpn = '0, inv_vpn = '0;
   logic [AW-1:0] fill_asid = '0, inv_asid = '0;
   logic [PW-1:0] fill_ppn = '0;
   logic [2:0] fill_perm = '0;

   always #2 clk = ~clk;

   xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .ASID_W(AW)) u0 (.*);

   int tests = 0, fails = 0;

   // reference table from the requirements
   logic          m_v [N];
   logic [VW-1:0] m_vpn [N];
   logic [AW-1:0] m_asid [N];
   logic [PW-1:0] m_ppn [N];
   logic [2:0]    m_perm [N];
   logic          m_g [N];
   int            m_ptr;

   task automatic model_op(input logic fl, input logic iv, input logic fi,
                           input int vpn, input int asid, input int ppn,
                           input int perm, input logic g);
      int idx;
      if (fl) begin
         for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      end else if (iv) begin
         for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == VW'(vpn) && (m_g[i] || m_asid[i] == AW'(asid)))
               m_v[i] = 1'b0;
      end else if (fi) begin
         idx = -1;
         for (int i = 0; i < N; i++)
            if (idx < 0 && m_v[i] && m_vpn[i] == VW'(vpn) && m_asid[i] == AW'(asid)) idx = i;
         for (int i = 0; i < N; i++)
            if (idx < 0 && !m_v[i]) idx = i;
         if (idx < 0) begin
            idx = m_ptr;
            m_ptr = (m_ptr + 1) % N;
         end
         m_v[idx] = 1'b1; m_vpn[idx] = VW'(vpn); m_asid[idx] = AW'(asid);
         m_ppn[idx] = PW'(ppn); m_perm[idx] = 3'(perm); m_g[idx] = g;
      end
   endtask

   task automatic do_op(input logic fl, input logic iv, input logic fi,
                        input int vpn, input int asid, input int ppn,
                        input int perm, input logic g);
      @(negedge clk);
      flush_en = fl; inv_en = iv; fill_en = fi;
      fill_vpn = VW'(vpn); fill_asid = AW'(asid); fill_ppn = PW'(ppn);
      fill_perm = 3'(perm); fill_glb = g;
      inv_vpn = VW'(vpn); inv_asid = AW'(asid);
      @(negedge clk);
      flush_en = 1'b0; inv_en = 1'b0; fill_en = 1'b0;
      model_op(fl, iv, fi, vpn, asid, ppn, perm, g);
   endtask

   task automatic fill(input int vpn, input int asid, input int ppn, input logic g);
      do_op(1'b0, 1'b0, 1'b1, vpn, asid, ppn, vpn % 8, g);
   endtask

   task automatic sweep(input string tag);
      logic eh; logic [PW-1:0] ep; logic [2:0] er;
      for (int v = 0; v < 16; v++) begin
         for (int a = 0; a < 4; a++) begin
            eh = 1'b0; ep = '0; er = '0;
            for (int i = N - 1; i >= 0; i--)
               if (m_v[i] && m_vpn[i] == VW'(v) && (m_g[i] || m_asid[i] == AW'(a))) begin
                  eh = 1'b1; ep = m_ppn[i]; er = m_perm[i];
               end
            @(negedge clk);
            lk_valid = 1'b1; lk_vpn = VW'(v); lk_asid = AW'(a);
            #1;
            tests++;
            if (lk_hit !== eh || (eh && (lk_ppn !== ep || lk_perm !== er))) begin
               fails++;
               $display("FAIL %s vpn=%0d asid=%0d got hit=%b ppn=%h perm=%b exp hit=%b ppn=%h perm=%b",
                        tag, v, a, lk_hit, lk_ppn, lk_perm, eh, ep, er);
            end
         end
      end
      lk_valid = 1'b0;
   endtask

   function automatic int pp(input int vpn, input int asid, input int k);
      return (vpn * 37 + asid * 1031 + k * 4099 + 5) & 20'hFFFFF;
   endfunction

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int lf;
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0; m_perm[i] = '0; m_g[i] = 0;
      end
      m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sweep("R2");
      // R8: fills land in free entries in order
      for (int v = 0; v < 8; v++) fill(v, 1, pp(v, 1, 0), 1'b0);
      sweep("R8");
      // R1: no request, no hit
      @(negedge clk); lk_valid = 1'b0; lk_vpn = '0; lk_asid = AW'(1); #1;
      tests++;
      if (lk_hit !== 1'b0) begin fails++; $display("FAIL R1 idle lookup got hit=%b exp 0", lk_hit); end
      // R9: pointer eviction from entry 0 on
      fill(8, 1, pp(8, 1, 0), 1'b0); sweep("R9");
      fill(9, 1, pp(9, 1, 0), 1'b0); sweep("R9");
      // R7: overwrite in place, pointer untouched
      fill(3, 1, pp(3, 1, 7), 1'b0); sweep("R7");
      fill(10, 1, pp(10, 1, 0), 1'b0); sweep("R9");
      // R5: same page, other tag
      fill(5, 2, pp(5, 2, 0), 1'b0); sweep("R5");
      // R4 then R8 reuse of freed slot
      do_op(1'b0, 1'b1, 1'b0, 4, 1, 0, 0, 1'b0); sweep("R4");
      fill(11, 3, pp(11, 3, 0), 1'b0); sweep("R8");
      // R6: global entry hits under every tag
      fill(12, 0, pp(12, 0, 0), 1'b1); sweep("R6");
      // R10: global and own entries both hit, lowest index answers
      fill(12, 2, pp(12, 2, 3), 1'b0); sweep("R10");
      // R4: global entry removed by invalidate under another tag
      do_op(1'b0, 1'b1, 1'b0, 12, 3, 0, 0, 1'b0); sweep("R4");
      // R4: invalidate and fill together, fill dropped
      do_op(1'b0, 1'b1, 1'b1, 13, 1, pp(13, 1, 0), 5, 1'b0); sweep("R4");
      // R3: flush beats invalidate and fill
      do_op(1'b1, 1'b1, 1'b1, 14, 1, pp(14, 1, 0), 2, 1'b0); sweep("R3");
      // R9: pointer kept across the flush
      for (int v = 0; v < 10; v++) fill(v + 2, v % 4, pp(v, v % 4, 1), 1'b0);
      sweep("R9");
      // R7: mixed refills over a crowded table
      lf = 7;
      for (int k = 0; k < 40; k++) begin
         lf = ((lf * 75) + 74) % 65537;
         fill(lf % 16, (lf / 16) % 4, pp(lf % 16, k, 2), (lf % 11) == 0);
         sweep("R7");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule